// File: doc/BRIEF.md
# Shared OUT-Endpoint Receive Buffer Controller

This block owns the single receive buffer that every OUT endpoint of a USB device shares. The buffer has two parts. One is a RAM of 37-bit words, each holding 32 payload bits and 5 status bits. The other is a short queue, built from registers, of 32-bit packet descriptors. The link layer announces each packet with a start pulse that carries the endpoint number and a SETUP marker. In that same cycle the controller either accepts the packet or tells the link layer to refuse it with NAK, or with NYET when the device runs at high speed.

An accepted packet streams its words into the RAM. When the packet ends without error, one descriptor is queued. When it ends with an error, the write pointer returns to where it stood at packet start. The bus-side reader pops a descriptor and then drains exactly the words that the descriptor's byte count implies. The space those words held is returned as one step when the last of them is read.

Top module: `rxf_ctrl`

## Requirements
- R1: After reset no descriptor is offered (`desc_valid`=0), no data is offered (`rd_valid`=0), and the whole data RAM (512 words) is free, so a packet on an endpoint whose maximum size is 1024 bytes is accepted.
- R2: In a cycle with `wr_start` and no packet in progress, exactly one of `rsp_accept`, `rsp_nak` and `rsp_nyet` is high. `rsp_accept` is high only if fewer than 4 descriptors are queued and the free data words are at least ceil(max packet bytes of `wr_ep` / 4). The maximum packet size of endpoint e is `ep_mps[e*11 +: 11]`.
- R3: A refused packet is answered with `rsp_nak` when `hs_mode`=0 and with `rsp_nyet` when `hs_mode`=1.
- R4: Data words are stored only inside an accepted packet and only up to its reserved word count. Words of a refused packet, and words beyond the reservation, never appear on the read side.
- R5: One cycle after `wr_end` with `wr_err`=0 a descriptor is offered. Its bits [3:0] hold the endpoint, bit 4 the SETUP flag, bits [15:5] the byte count from `wr_bytes`, and bits [31:16] are zero.
- R6: A packet ending with `wr_err`=1 queues no descriptor, and all the space it used becomes free again.
- R7: At most 4 descriptors are held. A fifth packet is refused even when the data RAM has room.
- R8: The data RAM holds 512 words: four 512-byte packets fit at once, or two 1024-byte packets, but not a third 1024-byte packet.
- R9: After a descriptor is popped, `rd_valid` stays high for exactly ceil(byte count / 4) word reads and then drops. The words appear in write order, and a cycle with `rd_ready`=0 holds the word in place.
- R10: Space freed by a drained packet is usable for acceptance on the cycle after the last word is read.
- R11: A zero-length packet queues a descriptor with byte count 0, and popping it presents no data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_mode | input | 1 | 1 = high-speed operation (refuse with NYET) |
| ep_mps | input | 176 | Max packet bytes per endpoint, 11 bits each, endpoint e at [e*11 +: 11] |
| wr_start | input | 1 | Packet start pulse from the link layer |
| wr_ep | input | 4 | Endpoint number, valid with `wr_start` |
| wr_setup | input | 1 | SETUP marker, valid with `wr_start` |
| wr_valid | input | 1 | Data word valid |
| wr_word | input | 37 | Data word: payload [31:0], status [36:32] |
| wr_end | input | 1 | Packet end pulse |
| wr_err | input | 1 | Packet ended in error, valid with `wr_end` |
| wr_bytes | input | 11 | Packet byte count, valid with `wr_end` |
| rsp_accept | output | 1 | Packet accepted (same cycle as `wr_start`) |
| rsp_nak | output | 1 | Packet refused, answer NAK |
| rsp_nyet | output | 1 | Packet refused, answer NYET |
| desc_valid | output | 1 | A descriptor is queued |
| desc_word | output | 32 | Head descriptor |
| desc_pop | input | 1 | Pop the head descriptor (ignored while draining) |
| rd_valid | output | 1 | Data word offered to the reader |
| rd_word | output | 37 | Data word offered to the reader |
| rd_ready | input | 1 | Reader takes the offered word |

## Verification
The admission decision is exercised in three ways. Small packets fill the descriptor queue while the RAM stays nearly empty, which isolates the slot limit. Large packets fill the RAM while slots remain free, which isolates the space limit. An abort followed by a large packet shows whether a rollback really returns the space. Refusals are repeated in both speed modes, which tells NAK and NYET apart. Oversized and refused word streams are checked by draining and comparing the read stream word for word. A seeded random mix of endpoints, sizes, aborts, stalls and drains is then checked against a bench model that tracks free words and queued descriptors.

// File: rtl/rxf_pkg.sv
// Package: shared widths and descriptor helpers for the receive buffer controller.
// Assumes a 4-bit endpoint number and an 11-bit byte count (max 1024 bytes).
package rxf_pkg;
    localparam int PAY_W  = 32;
    localparam int STAT_W = 5;
    localparam int WORD_W = PAY_W + STAT_W;
    localparam int EP_W   = 4;
    localparam int BC_W   = 11;
    localparam int DESC_W = 32;

    // Builds a descriptor word: ep [3:0], setup [4], byte count [15:5], rest zero.
    function automatic logic [DESC_W-1:0] make_desc(input logic [EP_W-1:0] ep,
                                                    input logic setup,
                                                    input logic [BC_W-1:0] bytes);
        return {16'h0000, bytes, setup, ep};
    endfunction

    // Word count that holds a given byte count (rounded up).
    function automatic logic [BC_W-1:0] words_of(input logic [BC_W-1:0] bytes);
        logic [BC_W:0] sum;
        sum = {1'b0, bytes} + (BC_W+1)'(3);
        return sum[BC_W:2] > 0 ? BC_W'(sum[BC_W:2]) : '0;
    endfunction
endpackage

// File: rtl/rxf_admit.sv
// Module: admission decision at packet start.
// Accepts when a descriptor slot is free and the free word count covers the
// endpoint's maximum packet size; otherwise selects NAK (full speed) or NYET
// (high speed). Purely combinational; assumes start is qualified by the caller.
module rxf_admit #(
    parameter int PTR_W = 10,
    parameter int BC_W  = 11
) (
    input  logic             start,
    input  logic             hs_mode,
    input  logic [BC_W-1:0]  mps_bytes,
    input  logic [PTR_W-1:0] free_words,
    input  logic             desc_full,
    output logic             accept,
    output logic             nak,
    output logic             nyet,
    output logic [BC_W-1:0]  reserve_words
);
    localparam int CMP_W = (PTR_W > BC_W ? PTR_W : BC_W) + 1;

    logic room;

    // Reserve words for the worst-case packet and compare with free space.
    always_comb begin
        reserve_words = rxf_pkg::words_of(mps_bytes);
        room          = CMP_W'(free_words) >= CMP_W'(reserve_words);
        accept        = start && room && !desc_full;
        nak           = start && !accept && !hs_mode;
        nyet          = start && !accept && hs_mode;
    end
endmodule

// File: rtl/rxf_data_ram.sv
// Module: packet data storage, one write port and one asynchronous read port.
// Assumes the caller never writes a location that is still awaiting a read.
// The storage array carries no reset; only pointers outside it are reset.
module rxf_data_ram #(
    parameter int DEPTH = 512,
    parameter int W     = 37,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_desc_queue.sv
// Module: small register FIFO of packet descriptors.
// Assumes the caller pushes only when not full and pops only when valid.
module rxf_desc_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    logic [W-1:0]  slot [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    // Advance an index with wrap at DEPTH.
    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
        return (32'(i) == DEPTH - 1) ? '0 : i + IW'(1);
    endfunction

    // Slot storage, written at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (push) begin
            slot[tail_q] <= din;
        end
    end

    // Head, tail and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= nxt(tail_q);
            if (pop)  head_q <= nxt(head_q);
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    assign dout  = slot[head_q];
    assign valid = count_q != '0;
    assign full  = 32'(count_q) == DEPTH;

    AST_DESC_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R7
    AST_DESC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> valid); // R9
endmodule

// File: rtl/rxf_ctrl.sv
// Module: shared OUT-endpoint receive buffer controller (top).
// Admits packets at start against slot and space limits, writes their words
// into the data RAM, queues a descriptor on clean end, rolls back on error,
// and drains one packet at a time to the reader. Assumes the link layer sends
// no more than ceil(wr_bytes/4) words and a wr_bytes no larger than the
// endpoint's maximum packet size; DATA_WORDS is a power of two.
module rxf_ctrl #(
    parameter int DATA_WORDS = 512,
    parameter int DESC_DEPTH = 4,
    parameter int NUM_EP     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hs_mode,
    input  logic [NUM_EP*rxf_pkg::BC_W-1:0] ep_mps,
    input  logic                           wr_start,
    input  logic [rxf_pkg::EP_W-1:0]       wr_ep,
    input  logic                           wr_setup,
    input  logic                           wr_valid,
    input  logic [rxf_pkg::WORD_W-1:0]     wr_word,
    input  logic                           wr_end,
    input  logic                           wr_err,
    input  logic [rxf_pkg::BC_W-1:0]       wr_bytes,
    output logic                           rsp_accept,
    output logic                           rsp_nak,
    output logic                           rsp_nyet,
    output logic                           desc_valid,
    output logic [rxf_pkg::DESC_W-1:0]     desc_word,
    input  logic                           desc_pop,
    output logic                           rd_valid,
    output logic [rxf_pkg::WORD_W-1:0]     rd_word,
    input  logic                           rd_ready
);
    import rxf_pkg::*;

    localparam int AW    = $clog2(DATA_WORDS);
    localparam int PTR_W = AW + 1;

    logic [PTR_W-1:0] wr_ptr_q, base_q, rel_ptr_q, rd_ptr_q;
    logic [PTR_W-1:0] used_words, free_words, wr_ptr_inc;
    logic             in_pkt_q, draining_q;
    logic [EP_W-1:0]  cur_ep_q;
    logic             cur_setup_q;
    logic [BC_W-1:0]  res_q, cnt_q, remain_q, reserve_words, pop_words;
    logic [BC_W-1:0]  mps_sel;
    logic             start_ok, accept, wr_fire, push, pop_fire, rd_fire, desc_full;

    // Endpoint maximum size lookup and occupancy arithmetic.
    always_comb begin
        mps_sel    = ep_mps[32'(wr_ep)*BC_W +: BC_W];
        used_words = wr_ptr_q - rel_ptr_q;
        free_words = PTR_W'(DATA_WORDS) - used_words;
        start_ok   = wr_start && !in_pkt_q;
        wr_fire    = in_pkt_q && wr_valid && (cnt_q < res_q);
        wr_ptr_inc = wr_ptr_q + PTR_W'(wr_fire);
        push       = in_pkt_q && wr_end && !wr_err;
        pop_fire   = desc_valid && desc_pop && !draining_q;
        pop_words  = words_of(desc_word[15:5]);
        rd_fire    = draining_q && rd_ready;
    end

    rxf_admit #(.PTR_W(PTR_W), .BC_W(BC_W)) u_admit (
        .start         (start_ok),
        .hs_mode       (hs_mode),
        .mps_bytes     (mps_sel),
        .free_words    (free_words),
        .desc_full     (desc_full),
        .accept        (accept),
        .nak           (rsp_nak),
        .nyet          (rsp_nyet),
        .reserve_words (reserve_words)
    );
    assign rsp_accept = accept;

    rxf_data_ram #(.DEPTH(DATA_WORDS), .W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_ptr_q[AW-1:0]),
        .wdata (wr_word),
        .raddr (rd_ptr_q[AW-1:0]),
        .rdata (rd_word)
    );

    rxf_desc_queue #(.DEPTH(DESC_DEPTH), .W(DESC_W)) u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (make_desc(cur_ep_q, cur_setup_q, wr_bytes)),
        .pop   (pop_fire),
        .dout  (desc_word),
        .valid (desc_valid),
        .full  (desc_full)
    );

    // Write side: packet open, word count, commit or roll back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q    <= 1'b0;
            wr_ptr_q    <= '0;
            base_q      <= '0;
            cur_ep_q    <= '0;
            cur_setup_q <= 1'b0;
            res_q       <= '0;
            cnt_q       <= '0;
        end else if (accept) begin
            in_pkt_q    <= 1'b1;
            base_q      <= wr_ptr_q;
            cur_ep_q    <= wr_ep;
            cur_setup_q <= wr_setup;
            res_q       <= reserve_words;
            cnt_q       <= '0;
        end else if (in_pkt_q && wr_end) begin
            in_pkt_q <= 1'b0;
            wr_ptr_q <= wr_err ? base_q : wr_ptr_inc;
        end else begin
            wr_ptr_q <= wr_ptr_inc;
            cnt_q    <= cnt_q + BC_W'(wr_fire);
        end
    end

    // Read side: load word count on pop, drain, release space at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining_q <= 1'b0;
            remain_q   <= '0;
            rd_ptr_q   <= '0;
            rel_ptr_q  <= '0;
        end else if (pop_fire) begin
            draining_q <= pop_words != '0;
            remain_q   <= pop_words;
        end else if (rd_fire) begin
            rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            remain_q <= remain_q - BC_W'(1);
            if (remain_q == BC_W'(1)) begin
                draining_q <= 1'b0;
                rel_ptr_q  <= rd_ptr_q + PTR_W'(1);
            end
        end
    end

    assign rd_valid = draining_q;

    AST_RSP_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rsp_accept, rsp_nak, rsp_nyet})); // R2
    AST_RSP_PRESENT:    assert property (@(posedge clk) disable iff (!rst_n) (wr_start && !in_pkt_q) |-> $countones({rsp_accept, rsp_nak, rsp_nyet}) == 1); // R2
    AST_NAK_FS_ONLY:    assert property (@(posedge clk) disable iff (!rst_n) (rsp_nak || rsp_nyet) |-> (rsp_nyet == hs_mode)); // R3
    AST_FILL_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) 32'(used_words) <= DATA_WORDS); // R8
    AST_ABORT_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n) (in_pkt_q && wr_end && wr_err && !accept) |=> wr_ptr_q == $past(base_q)); // R6
    AST_FREE_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n) (draining_q && rd_ready && remain_q == BC_W'(1)) |=> (rel_ptr_q == rd_ptr_q && !rd_valid)); // R10
endmodule

// File: tb/tb_rxf_ctrl.sv
module tb_rxf_ctrl;
    localparam int NEP = 16;
    localparam int RAMW = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_mode = 1'b0;
    logic [NEP*11-1:0] ep_mps;
    logic wr_start = 0, wr_setup = 0, wr_valid = 0, wr_end = 0, wr_err = 0;
    logic [3:0] wr_ep = 0;
    logic [36:0] wr_word = 0;
    logic [10:0] wr_bytes = 0;
    logic rsp_accept, rsp_nak, rsp_nyet, desc_valid, rd_valid;
    logic [31:0] desc_word;
    logic [36:0] rd_word;
    logic desc_pop = 0, rd_ready = 0;

    rxf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .ep_mps(ep_mps),
        .wr_start(wr_start), .wr_ep(wr_ep), .wr_setup(wr_setup),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_end(wr_end),
        .wr_err(wr_err), .wr_bytes(wr_bytes), .rsp_accept(rsp_accept),
        .rsp_nak(rsp_nak), .rsp_nyet(rsp_nyet), .desc_valid(desc_valid),
        .desc_word(desc_word), .desc_pop(desc_pop), .rd_valid(rd_valid),
        .rd_word(rd_word), .rd_ready(rd_ready)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    logic [36:0] exp_data [$];
    int exp_ep [$];
    int exp_setup [$];
    int exp_bytes [$];
    int occ = 0;

    function automatic int mps_of(input int ep);
        return int'(ep_mps[ep*11 +: 11]);
    endfunction

    function automatic int wds(input int bytes);
        return (bytes + 3) / 4;
    endfunction

    function automatic bit model_accept(input int ep);
        return (exp_bytes.size() < 4) && ((RAMW - occ) >= wds(mps_of(ep)));
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Sends one packet; called and returns at a negedge.
    task automatic send_pkt(input int ep, input int setup, input int nbytes,
                            input int nsent, input bit abort, input string rq);
        bit acc;
        int rsv;
        logic [36:0] tmp [$];
        wr_start = 1; wr_ep = 4'(ep); wr_setup = setup[0];
        #1;
        acc = model_accept(ep);
        rsv = wds(mps_of(ep));
        chk(rsp_accept == acc, rq, "accept", rsp_accept, acc);
        chk(rsp_nak == (!acc && !hs_mode), "R3", "nak", rsp_nak, !acc && !hs_mode);
        chk(rsp_nyet == (!acc && hs_mode), "R3", "nyet", rsp_nyet, !acc && hs_mode);
        @(negedge clk);
        wr_start = 0;
        for (int i = 0; i < nsent; i++) begin
            wr_valid = 1;
            wr_word = {5'($urandom), 32'($urandom)};
            if (acc && i < rsv) tmp.push_back(wr_word);
            @(negedge clk);
        end
        wr_valid = 0;
        wr_end = 1; wr_err = abort; wr_bytes = 11'(nbytes);
        @(negedge clk);
        wr_end = 0; wr_err = 0;
        if (acc && !abort) begin
            foreach (tmp[k]) exp_data.push_back(tmp[k]);
            exp_ep.push_back(ep); exp_setup.push_back(setup); exp_bytes.push_back(nbytes);
            occ += tmp.size();
        end
    endtask

    // Pops and drains one descriptor; called and returns at a negedge.
    task automatic drain(input string rq);
        int n, ep, st, by;
        logic [31:0] ed;
        logic [36:0] ew;
        if (exp_bytes.size() == 0) return;
        ep = exp_ep.pop_front(); st = exp_setup.pop_front(); by = exp_bytes.pop_front();
        ed = {16'h0, 11'(by), st[0], 4'(ep)};
        #1;
        chk(desc_valid == 1'b1, "R5", "desc_valid", desc_valid, 1);
        chk(desc_word == ed, "R5", "desc_word", desc_word, ed);
        @(negedge clk); desc_pop = 1;
        @(negedge clk); desc_pop = 0;
        n = wds(by);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 5 == 0) begin
                rd_ready = 0;
                #1;
                chk(rd_valid == 1'b1, "R9", "stall valid", rd_valid, 1);
                @(negedge clk);
                chk(rd_word == exp_data[0], "R9", "stall hold", rd_word, exp_data[0]);
            end
            rd_ready = 1;
            #1;
            ew = exp_data.pop_front();
            chk(rd_valid == 1'b1, rq, "rd_valid", rd_valid, 1);
            chk(rd_word == ew, rq, "rd_word", rd_word, ew);
            @(negedge clk);
        end
        rd_ready = 0;
        #1;
        chk(rd_valid == 1'b0, rq, "rd_valid after drain", rd_valid, 0);
        occ -= n;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < NEP; e++) ep_mps[e*11 +: 11] = 11'd64;
        ep_mps[1*11 +: 11] = 11'd512;
        ep_mps[2*11 +: 11] = 11'd1024;
        ep_mps[3*11 +: 11] = 11'd8;
        ep_mps[4*11 +: 11] = 11'd200;
        ep_mps[5*11 +: 11] = 11'd1023;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(desc_valid == 0, "R1", "desc_valid", desc_valid, 0);
        chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
        @(negedge clk);
        send_pkt(2, 0, 1024, 256, 0, "R1");
        drain("R9");

        // R7: four small packets fill the descriptor queue, fifth refused
        for (int i = 0; i < 4; i++) send_pkt(0, i % 2, 8 * (i + 1), 2 * (i + 1), 0, "R7");
        send_pkt(0, 0, 8, 2, 0, "R7");      // refused, NAK; words ignored (R4)
        hs_mode = 1;
        send_pkt(3, 0, 8, 2, 0, "R7");      // refused, NYET (R3)
        hs_mode = 0;
        for (int i = 0; i < 4; i++) drain("R4");

        // R8: two 1024-byte packets fit, third refused, also 64-byte refused
        send_pkt(2, 0, 1024, 256, 0, "R8");
        send_pkt(2, 0, 1000, 250, 0, "R8");
        send_pkt(2, 0, 1024, 256, 0, "R8");
        hs_mode = 1;
        send_pkt(0, 0, 64, 16, 0, "R8");
        hs_mode = 0;
        // R10: space freed by the drain is usable at once
        drain("R9");
        @(negedge clk);
        send_pkt(2, 0, 1024, 256, 0, "R10");
        drain("R9");
        drain("R9");

        // R8: four 512-byte packets
        for (int i = 0; i < 4; i++) send_pkt(1, 0, 512, 128, 0, "R8");
        for (int i = 0; i < 4; i++) drain("R9");

        // R6: abort rolls back, then two full packets still fit
        send_pkt(2, 0, 1024, 256, 0, "R6");
        send_pkt(2, 0, 1024, 200, 1, "R6");
        send_pkt(2, 1, 1024, 256, 0, "R6");
        #1;
        chk(exp_bytes.size() == 2, "R6", "queued count", exp_bytes.size(), 2);
        drain("R6");
        drain("R6");

        // R11: zero-length packet
        send_pkt(3, 1, 0, 0, 0, "R11");
        drain("R11");
        #1;
        chk(desc_valid == 0, "R11", "queue empty", desc_valid, 0);
        @(negedge clk);

        // R4: words beyond the reservation are dropped
        send_pkt(0, 0, 64, 20, 0, "R4");
        drain("R4");

        // R5: SETUP packet descriptor
        send_pkt(0, 1, 8, 2, 0, "R5");
        drain("R5");

        // Random mix
        for (int it = 0; it < 200; it++) begin
            int sel, ep, by, mps;
            sel = int'($urandom % 3);
            hs_mode = $urandom % 2;
            if (sel != 0 || exp_bytes.size() == 0) begin
                ep = int'($urandom % 6);
                mps = mps_of(ep);
                by = int'($urandom % (mps + 1));
                send_pkt(ep, int'($urandom % 2), by, wds(by), ($urandom % 8) == 0, "R2");
            end else begin
                drain("R9");
                @(negedge clk);
            end
        end
        while (exp_bytes.size() != 0) drain("R9");
        summary();
    end
endmodule